// File: doc/BRIEF.md
# Packet Memory Responder with Atomic Swap

This block is a single-ported, byte-addressable store that serves one request packet per clock. A request can be a read, a write, an unconditional swap, a compare-and-swap, a cache-maintenance operation (invalidate or clean) or an eviction notice. A single decode step sorts each packet into one of these classes. The storage is read combinationally and updated at the same clock edge, so a swap is a full read-modify-write in one cycle. A response, when the packet asks for one, is registered and appears one cycle after the request.

Plain writes are gated by a `wr_allowed_i` input that an external reservation monitor drives. Swaps are never gated. Each requestor has its own set of statistics counters: read requests, read bytes, instruction-fetch bytes, write requests, write bytes, and other (swap) requests. `stat_sel_i` selects which requestor's counters appear on the statistics outputs.

Top module: `mem_responder`

## Requirements
- R1: After reset, `rsp_valid_o` and `err_o` are low and every statistics counter of every requestor reads zero.
- R2: A read (command 0) returns in `rsp_data_o` the bytes selected by the byte enables, left in their own lanes, with all other lanes zero. The size code maps 0,1,2,3 to 1,2,4,8 bytes. Lane k holds address byte offset k (little-endian), and the enables start at `req_addr_i[2:0]`. The read adds 1 to the requestor's read count and the size to its read bytes. When `req_ifetch_i` is set, it also adds the size to its instruction-fetch bytes.
- R3: A write (command 1) changes the enabled bytes only when `wr_allowed_i` is high. In that case it adds 1 to the write count and the size to the write bytes. A blocked write changes no memory and no counter. Its response data is zero.
- R4: A swap (command 2) returns the old enabled bytes and writes the request data into them whatever `wr_allowed_i` is. It adds 1 to the requestor's other count and touches no read or write counter.
- R5: A compare-and-swap (command 3) returns the old enabled bytes. It writes only when they equal the same lanes of `req_cmp_i`, and it adds 1 to the other count. Sizes of 1 or 2 bytes raise `err_o`.
- R6: Invalidate (command 4) and clean (command 5) change no memory and no counter. They respond with zero data when a response is needed.
- R7: A request with `req_cache_owned_i` set, or with command 6 (clean eviction) or 7 (clean writeback), has no effect: no memory change, no response, no error and no counter change.
- R8: Commands 8 to 15 raise `err_o` for one cycle, one cycle after the request, and produce no response and no effect.
- R9: A read, write, swap or compare-and-swap whose address offset is not a multiple of its size raises `err_o` and has no effect.
- R10: A response is produced only when `req_need_rsp_i` is high. It appears one cycle after the request and carries the request's command and requestor id.
- R11: The counters of each requestor advance only for that requestor's requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_cmd_i | input | 4 | Command code |
| req_addr_i | input | AW | Byte address, AW = log2(DEPTH)+3 |
| req_size_i | input | 2 | Size code (1,2,4,8 bytes) |
| req_data_i | input | 64 | Write or swap data, in lanes |
| req_cmp_i | input | 64 | Compare value for compare-and-swap, in lanes |
| req_id_i | input | IDW | Requestor id |
| req_need_rsp_i | input | 1 | Request expects a response |
| req_cache_owned_i | input | 1 | A cache is answering this request |
| req_ifetch_i | input | 1 | Read is an instruction fetch |
| wr_allowed_i | input | 1 | Reservation check allows a plain write |
| rsp_valid_o | output | 1 | Response present |
| rsp_cmd_o | output | 4 | Command of the answered request |
| rsp_id_o | output | IDW | Requestor id of the answered request |
| rsp_data_o | output | 64 | Response data |
| err_o | output | 1 | Illegal request seen last cycle |
| stat_sel_i | input | IDW | Requestor whose counters are shown |
| stat_rd_o | output | CNT_W | Read requests |
| stat_rd_bytes_o | output | CNT_W | Bytes read |
| stat_if_bytes_o | output | CNT_W | Instruction-fetch bytes read |
| stat_wr_o | output | CNT_W | Write requests |
| stat_wr_bytes_o | output | CNT_W | Bytes written |
| stat_oth_o | output | CNT_W | Swap requests |

## Verification
The bench uses DEPTH of 16 words and NUM_REQ of 4 requestors. The small array lets a bench-side byte model follow every lane. Four requestors let the counters of several ids be checked against each other after mixed traffic. With CNT_W left at 16, no counter wraps, so each count can be compared exactly. All four sizes, aligned and misaligned offsets, blocked and allowed writes, and matching and mismatching compare values are each driven at least once.

// File: rtl/mem_resp_pkg.sv
package mem_resp_pkg;
  localparam int LANES  = 8;
  localparam int DATA_W = LANES * 8;

  localparam logic [3:0] CMD_READ    = 4'd0;
  localparam logic [3:0] CMD_WRITE   = 4'd1;
  localparam logic [3:0] CMD_SWAP    = 4'd2;
  localparam logic [3:0] CMD_CSWAP   = 4'd3;
  localparam logic [3:0] CMD_INVAL   = 4'd4;
  localparam logic [3:0] CMD_CLEAN   = 4'd5;
  localparam logic [3:0] CMD_EVICT   = 4'd6;
  localparam logic [3:0] CMD_WBCLEAN = 4'd7;

  typedef enum logic [2:0] {
    OP_READ, OP_WRITE, OP_SWAP, OP_CSWAP, OP_MAINT, OP_DROP, OP_ERR
  } op_e;
endpackage

// File: rtl/mem_resp_decode.sv
module mem_resp_decode
  import mem_resp_pkg::*;
(
  input  logic [3:0]       cmd_i,
  input  logic [1:0]       size_i,
  input  logic [2:0]       off_i,
  input  logic             cache_owned_i,
  output op_e              op_o,
  output logic [LANES-1:0] be_o,
  output logic [3:0]       nbytes_o
);
  logic [LANES-1:0] base_mask;
  logic             misalign;

  always_comb begin
    nbytes_o = 4'd1 << size_i;
    unique case (size_i)
      2'd0:    base_mask = 8'h01;
      2'd1:    base_mask = 8'h03;
      2'd2:    base_mask = 8'h0f;
      default: base_mask = 8'hff;
    endcase
    be_o     = base_mask << off_i;
    misalign = |(off_i & (nbytes_o[2:0] - 3'd1)) || (size_i == 2'd3 && off_i != 3'd0);
  end

  always_comb begin
    if (cache_owned_i) op_o = OP_DROP;
    else begin
      case (cmd_i)
        CMD_READ:            op_o = misalign ? OP_ERR : OP_READ;
        CMD_WRITE:           op_o = misalign ? OP_ERR : OP_WRITE;
        CMD_SWAP:            op_o = misalign ? OP_ERR : OP_SWAP;
        CMD_CSWAP:           op_o = (misalign || !size_i[1]) ? OP_ERR : OP_CSWAP;
        CMD_INVAL, CMD_CLEAN:  op_o = OP_MAINT;
        CMD_EVICT, CMD_WBCLEAN: op_o = OP_DROP;
        default:             op_o = OP_ERR;
      endcase
    end
  end
endmodule

// File: rtl/mem_resp_array.sv
module mem_resp_array
  import mem_resp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_en_i,
  input  logic [LANES-1:0]  wr_be_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] store_q [DEPTH];
  logic [DATA_W-1:0] merged;

  assign rd_data_o = store_q[idx_i];

  // byte-lane merge of new data into the old word
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*8 +: 8] = wr_be_i[g] ? wr_data_i[g*8 +: 8] : rd_data_o[g*8 +: 8];
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) store_q[idx_i] <= merged;
  end
endmodule

// File: rtl/mem_resp_stats.sv
module mem_resp_stats #(
  parameter int NUM_REQ = 4,
  parameter int CNT_W   = 16,
  localparam int IDW    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDW-1:0]   id_i,
  input  logic             ev_rd_i,
  input  logic             ev_wr_i,
  input  logic             ev_oth_i,
  input  logic             ifetch_i,
  input  logic [3:0]       nbytes_i,
  input  logic [IDW-1:0]   sel_i,
  output logic [CNT_W-1:0] rd_o,
  output logic [CNT_W-1:0] rd_bytes_o,
  output logic [CNT_W-1:0] if_bytes_o,
  output logic [CNT_W-1:0] wr_o,
  output logic [CNT_W-1:0] wr_bytes_o,
  output logic [CNT_W-1:0] oth_o
);
  logic [CNT_W-1:0] rd_q [NUM_REQ];
  logic [CNT_W-1:0] rdb_q [NUM_REQ];
  logic [CNT_W-1:0] ifb_q [NUM_REQ];
  logic [CNT_W-1:0] wr_q [NUM_REQ];
  logic [CNT_W-1:0] wrb_q [NUM_REQ];
  logic [CNT_W-1:0] oth_q [NUM_REQ];
  logic [CNT_W-1:0] nb_ext;

  assign nb_ext = CNT_W'(nbytes_i);

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    logic hit;
    assign hit = (id_i == IDW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_q[g]  <= '0;
        rdb_q[g] <= '0;
        ifb_q[g] <= '0;
        wr_q[g]  <= '0;
        wrb_q[g] <= '0;
        oth_q[g] <= '0;
      end else if (hit) begin
        if (ev_rd_i) begin
          rd_q[g]  <= rd_q[g] + 1'b1;
          rdb_q[g] <= rdb_q[g] + nb_ext;
          if (ifetch_i) ifb_q[g] <= ifb_q[g] + nb_ext;
        end
        if (ev_wr_i) begin
          wr_q[g]  <= wr_q[g] + 1'b1;
          wrb_q[g] <= wrb_q[g] + nb_ext;
        end
        if (ev_oth_i) oth_q[g] <= oth_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    rd_o = '0; rd_bytes_o = '0; if_bytes_o = '0;
    wr_o = '0; wr_bytes_o = '0; oth_o = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (sel_i == IDW'(i)) begin
        rd_o       = rd_q[i];
        rd_bytes_o = rdb_q[i];
        if_bytes_o = ifb_q[i];
        wr_o       = wr_q[i];
        wr_bytes_o = wrb_q[i];
        oth_o      = oth_q[i];
      end
    end
  end
endmodule

// File: rtl/mem_responder.sv
module mem_responder
  import mem_resp_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NUM_REQ = 4,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int AW     = IDX_W + 3,
  localparam int IDW    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [3:0]        req_cmd_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [63:0]       req_data_i,
  input  logic [63:0]       req_cmp_i,
  input  logic [IDW-1:0]    req_id_i,
  input  logic              req_need_rsp_i,
  input  logic              req_cache_owned_i,
  input  logic              req_ifetch_i,
  input  logic              wr_allowed_i,
  output logic              rsp_valid_o,
  output logic [3:0]        rsp_cmd_o,
  output logic [IDW-1:0]    rsp_id_o,
  output logic [63:0]       rsp_data_o,
  output logic              err_o,
  input  logic [IDW-1:0]    stat_sel_i,
  output logic [CNT_W-1:0]  stat_rd_o,
  output logic [CNT_W-1:0]  stat_rd_bytes_o,
  output logic [CNT_W-1:0]  stat_if_bytes_o,
  output logic [CNT_W-1:0]  stat_wr_o,
  output logic [CNT_W-1:0]  stat_wr_bytes_o,
  output logic [CNT_W-1:0]  stat_oth_o
);
  op_e               op;
  logic [LANES-1:0]  be;
  logic [3:0]        nbytes;
  logic [DATA_W-1:0] bit_mask;
  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] old_lanes;
  logic              cmp_eq;
  logic              wr_en;
  logic              answers;

  mem_resp_decode u_dec (
    .cmd_i         (req_cmd_i),
    .size_i        (req_size_i),
    .off_i         (req_addr_i[2:0]),
    .cache_owned_i (req_cache_owned_i),
    .op_o          (op),
    .be_o          (be),
    .nbytes_o      (nbytes)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign bit_mask[g*8 +: 8] = {8{be[g]}};
  end

  assign old_lanes = old_word & bit_mask;
  assign cmp_eq    = (old_lanes == (req_cmp_i & bit_mask));

  always_comb begin
    wr_en = 1'b0;
    if (req_valid_i) begin
      unique case (op)
        OP_WRITE: wr_en = wr_allowed_i;
        OP_SWAP:  wr_en = 1'b1;
        OP_CSWAP: wr_en = cmp_eq;
        default:  wr_en = 1'b0;
      endcase
    end
  end

  assign answers = (op == OP_READ) || (op == OP_WRITE) || (op == OP_SWAP) ||
                   (op == OP_CSWAP) || (op == OP_MAINT);

  mem_resp_array #(.DEPTH(DEPTH)) u_arr (
    .clk_i     (clk_i),
    .idx_i     (req_addr_i[AW-1:3]),
    .wr_en_i   (wr_en),
    .wr_be_i   (be),
    .wr_data_i (req_data_i),
    .rd_data_o (old_word)
  );

  mem_resp_stats #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) u_stats (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .id_i       (req_id_i),
    .ev_rd_i    (req_valid_i && op == OP_READ),
    .ev_wr_i    (req_valid_i && op == OP_WRITE && wr_allowed_i),
    .ev_oth_i   (req_valid_i && (op == OP_SWAP || op == OP_CSWAP)),
    .ifetch_i   (req_ifetch_i),
    .nbytes_i   (nbytes),
    .sel_i      (stat_sel_i),
    .rd_o       (stat_rd_o),
    .rd_bytes_o (stat_rd_bytes_o),
    .if_bytes_o (stat_if_bytes_o),
    .wr_o       (stat_wr_o),
    .wr_bytes_o (stat_wr_bytes_o),
    .oth_o      (stat_oth_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_cmd_o   <= '0;
      rsp_id_o    <= '0;
      rsp_data_o  <= '0;
      err_o       <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i && req_need_rsp_i && answers;
      err_o       <= req_valid_i && (op == OP_ERR);
      if (req_valid_i) begin
        rsp_cmd_o  <= req_cmd_i;
        rsp_id_o   <= req_id_i;
        rsp_data_o <= (op == OP_READ || op == OP_SWAP || op == OP_CSWAP) ? old_lanes : '0;
      end
    end
  end
endmodule

// File: rtl/mem_responder_chk.sv
module mem_responder_chk #(
  parameter int AW  = 7,
  parameter int IDW = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_valid_i,
  input logic [3:0]     req_cmd_i,
  input logic [1:0]     req_size_i,
  input logic [IDW-1:0] req_id_i,
  input logic           req_need_rsp_i,
  input logic           req_cache_owned_i,
  input logic           rsp_valid_o,
  input logic [IDW-1:0] rsp_id_o,
  input logic           err_o
);
  assert_drop_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (req_cache_owned_i || req_cmd_i == 4'd6 || req_cmd_i == 4'd7)
    |=> !rsp_valid_o && !err_o);

  assert_bad_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_cache_owned_i && req_cmd_i[3] |=> err_o && !rsp_valid_o);

  assert_cswap_size_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_cache_owned_i && req_cmd_i == 4'd3 && !req_size_i[1] |=> err_o);

  assert_no_unasked_rsp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_need_rsp_i |=> !rsp_valid_o);

  assert_rsp_id_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_need_rsp_i |=> !rsp_valid_o || rsp_id_o == $past(req_id_i));

  assert_err_no_rsp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && rsp_valid_o));
endmodule

bind mem_responder mem_responder_chk #(.AW(AW), .IDW(IDW)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .req_valid_i       (req_valid_i),
  .req_cmd_i         (req_cmd_i),
  .req_size_i        (req_size_i),
  .req_id_i          (req_id_i),
  .req_need_rsp_i    (req_need_rsp_i),
  .req_cache_owned_i (req_cache_owned_i),
  .rsp_valid_o       (rsp_valid_o),
  .rsp_id_o          (rsp_id_o),
  .err_o             (err_o)
);

// File: tb/mem_responder_test.sv
`timescale 1ns/1ps
module mem_responder_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH   = 16;
  localparam int NUM_REQ = 4;
  localparam int CNT_W   = 16;
  localparam int AW      = $clog2(DEPTH) + 3;
  localparam int IDW     = $clog2(NUM_REQ);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, need = 1'b0, cache = 1'b0, ifetch = 1'b0, allow = 1'b0;
  logic [3:0] cmd = '0;
  logic [AW-1:0] addr = '0;
  logic [1:0] size = '0;
  logic [63:0] wdata = '0, cmpv = '0;
  logic [IDW-1:0] id = '0, sel = '0;
  logic rsp_valid, err;
  logic [3:0] rsp_cmd;
  logic [IDW-1:0] rsp_id;
  logic [63:0] rsp_data;
  logic [CNT_W-1:0] s_rd, s_rdb, s_ifb, s_wr, s_wrb, s_oth;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_responder #(.DEPTH(DEPTH), .NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_cmd_i(cmd),
    .req_addr_i(addr), .req_size_i(size), .req_data_i(wdata), .req_cmp_i(cmpv),
    .req_id_i(id), .req_need_rsp_i(need), .req_cache_owned_i(cache),
    .req_ifetch_i(ifetch), .wr_allowed_i(allow), .rsp_valid_o(rsp_valid),
    .rsp_cmd_o(rsp_cmd), .rsp_id_o(rsp_id), .rsp_data_o(rsp_data), .err_o(err),
    .stat_sel_i(sel), .stat_rd_o(s_rd), .stat_rd_bytes_o(s_rdb),
    .stat_if_bytes_o(s_ifb), .stat_wr_o(s_wr), .stat_wr_bytes_o(s_wrb),
    .stat_oth_o(s_oth)
  );

  typedef struct packed { logic [3:0] cmd; logic [IDW-1:0] id; logic [63:0] data; } exp_t;
  exp_t exp_q[$];

  int checks = 0, failures = 0;
  logic [7:0] model [DEPTH*8];
  int m_rd[NUM_REQ], m_rdb[NUM_REQ], m_ifb[NUM_REQ], m_wr[NUM_REQ], m_wrb[NUM_REQ], m_oth[NUM_REQ];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops expected responses as the design produces them (R10)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected response", {60'd0, rsp_cmd}, 64'd0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rsp_cmd == e.cmd && rsp_id == e.id, "R10 response cmd/id",
              {52'd0, rsp_cmd, 6'(rsp_id)}, {52'd0, e.cmd, 6'(e.id)});
          chk(rsp_data == e.data, "R2/R4/R5 response data", rsp_data, e.data);
        end
      end
    end
  end

  task automatic do_req(input logic [3:0] c, input logic [AW-1:0] a, input logic [1:0] sz,
                        input logic [63:0] d, input logic [63:0] cv, input logic [IDW-1:0] rid,
                        input bit nd, input bit co, input bit ifx, input bit al, input string tag);
    int n, off, base;
    logic [7:0] be;
    logic [63:0] old;
    bit mis, e_err, e_rsp, eq;
    exp_t e;
    n = 1 << sz; off = int'(a[2:0]); base = int'(a[AW-1:3]) * 8;
    be = 8'((16'd1 << n) - 1) << off;
    mis = (off % n) != 0;
    old = '0; eq = 1'b1;
    for (int k = 0; k < 8; k++)
      if (be[k]) begin
        old[k*8 +: 8] = model[base+k];
        if (model[base+k] != cv[k*8 +: 8]) eq = 1'b0;
      end
    e_err = 1'b0; e_rsp = 1'b0;
    e.cmd = c; e.id = rid; e.data = '0;
    if (!co && c <= 4'd3 && (mis || (c == 4'd3 && sz < 2))) e_err = 1'b1;
    else if (!co && c >= 4'd8) e_err = 1'b1;
    else if (!co && c <= 4'd5) begin
      e_rsp = nd;
      case (c)
        4'd0: begin e.data = old; m_rd[rid]++; m_rdb[rid] += n; if (ifx) m_ifb[rid] += n; end
        4'd1: if (al) begin
                for (int k = 0; k < 8; k++) if (be[k]) model[base+k] = d[k*8 +: 8];
                m_wr[rid]++; m_wrb[rid] += n;
              end
        4'd2, 4'd3: begin
                e.data = old; m_oth[rid]++;
                if (c == 4'd2 || eq)
                  for (int k = 0; k < 8; k++) if (be[k]) model[base+k] = d[k*8 +: 8];
              end
        default: ;
      endcase
    end
    @(negedge clk);
    cmd = c; addr = a; size = sz; wdata = d; cmpv = cv; id = rid;
    need = nd; cache = co; ifetch = ifx; allow = al; req_valid = 1'b1;
    if (e_rsp) exp_q.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(err == e_err, tag, {63'd0, err}, {63'd0, e_err});
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] sz, input logic [IDW-1:0] rid, input string tag);
    do_req(4'd0, a, sz, '0, '0, rid, 1, 0, 0, 0, tag);
  endtask

  task automatic check_stats(input string tag);
    for (int r = 0; r < NUM_REQ; r++) begin
      @(negedge clk); sel = IDW'(r); #1;
      chk(s_rd == CNT_W'(m_rd[r]), {tag, " rd count"}, 64'(s_rd), 64'(m_rd[r]));
      chk(s_rdb == CNT_W'(m_rdb[r]), {tag, " rd bytes"}, 64'(s_rdb), 64'(m_rdb[r]));
      chk(s_ifb == CNT_W'(m_ifb[r]), {tag, " ifetch bytes"}, 64'(s_ifb), 64'(m_ifb[r]));
      chk(s_wr == CNT_W'(m_wr[r]), {tag, " wr count"}, 64'(s_wr), 64'(m_wr[r]));
      chk(s_wrb == CNT_W'(m_wrb[r]), {tag, " wr bytes"}, 64'(s_wrb), 64'(m_wrb[r]));
      chk(s_oth == CNT_W'(m_oth[r]), {tag, " other count"}, 64'(s_oth), 64'(m_oth[r]));
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NUM_REQ; i++) begin
      m_rd[i] = 0; m_rdb[i] = 0; m_ifb[i] = 0; m_wr[i] = 0; m_wrb[i] = 0; m_oth[i] = 0;
    end
    for (int i = 0; i < DEPTH*8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !err, "R1 outputs idle in reset", {62'd0, rsp_valid, err}, 64'd0);
    rst_n = 1'b1;
    check_stats("R1 reset");

    // fill every word with allowed 8-byte writes (R3)
    for (int w = 0; w < DEPTH; w++)
      do_req(4'd1, AW'(w*8), 2'd3, 64'h0102030405060708 * 64'(w + 1) ^ 64'hA5A5_0000_5A5A_0000,
             '0, IDW'(w % NUM_REQ), 1, 0, 0, 1, "R3 fill write");
    // reads of every size and lane (R2)
    for (int w = 0; w < DEPTH; w++) rd(AW'(w*8), 2'd3, IDW'(1), "R2 8-byte read");
    rd(AW'(8+5), 2'd0, 2, "R2 byte read lane 5");
    rd(AW'(16+6), 2'd1, 3, "R2 half read lanes 6-7");
    rd(AW'(24+4), 2'd2, 0, "R2 word read upper lanes");
    do_req(4'd0, AW'(32), 2'd2, '0, '0, 1, 1, 0, 1, 0, "R2 ifetch read");
    // blocked write leaves memory and counters alone (R3)
    do_req(4'd1, AW'(40), 2'd3, 64'hDEAD_BEEF_DEAD_BEEF, '0, 2, 1, 0, 0, 0, "R3 blocked write");
    rd(AW'(40), 2'd3, 2, "R3 read after blocked write");
    // byte write without response (R10, R3)
    do_req(4'd1, AW'(40+3), 2'd0, 64'h0000_0000_7700_0000, '0, 2, 0, 0, 0, 1, "R10 write no rsp");
    rd(AW'(40), 2'd3, 2, "R3 read after byte write");
    // swap ignores the write gate (R4)
    do_req(4'd2, AW'(48+4), 2'd2, 64'h1122_3344_0000_0000, '0, 3, 1, 0, 0, 0, "R4 swap");
    rd(AW'(48), 2'd3, 3, "R4 read after swap");
    // compare-and-swap equal then unequal (R5)
    do_req(4'd3, AW'(56), 2'd3, 64'hCAFE_F00D_0000_1111, {model[63], model[62], model[61], model[60],
           model[59], model[58], model[57], model[56]}, 0, 1, 0, 0, 0, "R5 cswap match");
    rd(AW'(56), 2'd3, 0, "R5 read after match");
    do_req(4'd3, AW'(56), 2'd2, 64'h0000_0000_9999_9999, 64'h0000_0000_1234_5678, 0, 1, 0, 0, 1, "R5 cswap miss");
    rd(AW'(56), 2'd3, 0, "R5 read after miss");
    do_req(4'd3, AW'(64), 2'd1, 64'h5555, '0, 1, 1, 0, 0, 1, "R5 cswap bad size err");
    // maintenance (R6)
    do_req(4'd4, AW'(72), 2'd3, 64'hFFFF, '0, 1, 1, 0, 0, 1, "R6 invalidate");
    do_req(4'd5, AW'(72), 2'd3, 64'hFFFF, '0, 1, 0, 0, 0, 1, "R6 clean");
    rd(AW'(72), 2'd3, 1, "R6 read after maintenance");
    // dropped requests (R7)
    do_req(4'd1, AW'(80), 2'd3, 64'h0BAD, '0, 2, 1, 1, 0, 1, "R7 cache-owned write");
    do_req(4'd6, AW'(80), 2'd3, 64'h0BAD, '0, 2, 1, 0, 0, 1, "R7 clean evict");
    do_req(4'd7, AW'(80), 2'd3, 64'h0BAD, '0, 2, 1, 0, 0, 1, "R7 clean writeback");
    do_req(4'd9, AW'(80), 2'd3, 64'h0BAD, '0, 2, 1, 1, 0, 1, "R7 cache-owned unknown");
    rd(AW'(80), 2'd3, 2, "R7 read after drops");
    // errors (R8, R9)
    do_req(4'd9, AW'(88), 2'd3, 64'h0BAD, '0, 3, 1, 0, 0, 1, "R8 unknown command");
    do_req(4'd15, AW'(88), 2'd0, 64'h0BAD, '0, 3, 1, 0, 0, 1, "R8 unknown command 15");
    do_req(4'd0, AW'(88+2), 2'd2, '0, '0, 3, 1, 0, 0, 0, "R9 misaligned read");
    do_req(4'd1, AW'(88+1), 2'd1, 64'hFFFF, '0, 3, 1, 0, 0, 1, "R9 misaligned write");
    rd(AW'(88), 2'd3, 3, "R9 read after rejects");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all responses seen", 64'(exp_q.size()), 64'd0);
    check_stats("R11 per-requestor");
    finish_run();
  end
endmodule